// File: doc/BRIEF.md
# Multicycle 8-bit Register Processor Core

This block is a small processor core that works on 8-bit signed values and runs 16-bit instruction words from an internal program store. The program store drives one instruction byte per clock onto an 8-bit bus. The core gathers the two bytes into an instruction word, decodes it, and chooses operand A from either the instruction's immediate byte or the addressed register. It then computes the result in a signed 8-bit ALU and writes that result back into the addressed register of an eight-entry register file.

Each instruction takes a fixed slot of eight clocks, and nothing overlaps between slots. Within a slot, clock 1 carries the upper instruction byte and clock 2 carries the lower byte. Decode happens on clock 3, the ALU evaluates on clock 4, and the register is written on clock 5. Clocks 6 to 8 are idle. The program store and the control each step their own slot counter in lockstep. The program counter advances once per slot and wraps after the last word. The program is a parameter of the top module. The bus, the latest ALU result and all register contents are brought out so the core can be observed.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous reset clears all eight registers and the ALU result to 0x00 and restarts fetch at program word 0. On the first clock after reset, the bus carries the upper byte of word 0.
- R2: In each 8-clock slot, the bus carries bits [15:8] of the current word on clock 1 and bits [7:0] on clock 2. It reads 0x00 on clocks 3 to 8.
- R3: The ALU result output takes the new value at the end of clock 4 of the slot. The addressed register takes it at the end of clock 5. Neither changes at any other clock.
- R4: The word layout is: opcode in bits [15:13], immediate-select flag in bit 12, immediate-enable flag in bit 11, register address in bits [10:8], immediate in bits [7:0]. Operand A is the immediate only when bits 12 and 11 are both 1. Otherwise it is the addressed register. Operand B is always the addressed register.
- R5: Opcode 000 writes A. Opcode 001 writes B+A modulo 256. Opcode 010 writes B−A modulo 256.
- R6: Opcode 011 writes the absolute value of B and ignores the immediate byte and bits 12 and 11. The absolute value of 0x80 is 0x80.
- R7: Opcode 100 writes B AND A, 101 writes B OR A, 110 writes B XOR A, and 111 writes the bitwise inverse of A.
- R8: A write-back changes only the register named by bits [10:8]. All other registers keep their values.
- R9: The program counter advances by one word per slot and returns to word 0 after word PROG_LEN−1.
- R10: The program MOV R0,32; ADD R0,16; SUB R0,64; ABS R0 (words 0x1820, 0x3810, 0x5840, 0x6000) leaves 0x10 in R0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrBus | output | 8 | Instruction byte bus from the program store |
| aluResult | output | 8 | Most recent registered ALU result |
| regContents | output | 64 | Register file contents, register i in bits [8i+7:8i] |

## Verification
The bench runs a program that wraps past its last word. It checks every slot clock by clock, so a design that places a write one clock early or late, or that drives the bus bytes in swapped order, shows a mismatch at that exact edge. The corner cases it targets are ADD wrapping 0x7F to 0x80, ABS of 0x80, ABS with a nonzero immediate and both flags set, and an instruction with only bit 12 set. A core that decoded the operand select from bit 12 alone would take the immediate in that last case and write the wrong sum. A reset in the middle of a slot must clear the registers and the result and restart at word 0. A counter that failed to clear would misalign the byte order on the bus.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int DATA_W   = 8;
  localparam int INSTR_W  = 16;
  localparam int NUM_REGS = 8;
  localparam int RADDR_W  = $clog2(NUM_REGS);

  // positions inside the instruction slot (0-based clock index)
  localparam int PH_FETCH_HI = 0;
  localparam int PH_FETCH_LO = 1;
  localparam int PH_DECODE   = 2;
  localparam int PH_EXEC     = 3;
  localparam int PH_WB       = 4;

  typedef enum logic [2:0] {
    OP_MOV = 3'b000,
    OP_ADD = 3'b001,
    OP_SUB = 3'b010,
    OP_ABS = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_NOT = 3'b111
  } aluOp_e;

  typedef struct packed {
    logic               aluEn;
    logic               wrEn;
    aluOp_e             op;
    logic               useImm;
    logic [RADDR_W-1:0] regAddr;
    logic [DATA_W-1:0]  imm;
  } ctrlStrobe_t;

endpackage

// File: rtl/cpu8_fetch.sv
module cpu8_fetch
  import cpu8_pkg::*;
#(
  parameter int SLOT_LEN = 8,
  parameter int PROG_LEN = 4,
  parameter logic [PROG_LEN*INSTR_W-1:0] PROGRAM = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  output logic [DATA_W-1:0]             busByte,
  output logic [$clog2(SLOT_LEN)-1:0]   phase
);

  localparam int PH_W = $clog2(SLOT_LEN);
  localparam int PC_W = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_LEN - 1);

  logic [PC_W-1:0]    pc;
  logic [INSTR_W-1:0] curWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == PH_W'(SLOT_LEN - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (phase == PH_W'(PH_FETCH_LO)) begin
      pc <= (pc == PC_LAST) ? '0 : pc + 1'b1;
    end
  end

  assign curWord = PROGRAM[int'(pc)*INSTR_W +: INSTR_W];

  always_comb begin
    busByte = '0;
    if (phase == PH_W'(PH_FETCH_HI)) begin
      busByte = curWord[INSTR_W-1 -: DATA_W];
    end else if (phase == PH_W'(PH_FETCH_LO)) begin
      busByte = curWord[DATA_W-1:0];
    end
  end

  // R9: counter moves only in the lower-byte clock and wraps at the end
  a_r9_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_W'(PH_FETCH_LO)) |=> $stable(pc));
  a_r9_pc_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_W'(PH_FETCH_LO) && pc == PC_LAST) |=> (pc == '0));

endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
#(
  parameter int SLOT_LEN = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           busByte,
  output ctrlStrobe_t                 strobe,
  output logic [$clog2(SLOT_LEN)-1:0] phase
);

  localparam int PH_W = $clog2(SLOT_LEN);

  logic [DATA_W-1:0]  hiByte;
  logic [INSTR_W-1:0] instrReg;
  aluOp_e             decOp;
  logic               decUseImm;
  logic [RADDR_W-1:0] decAddr;
  logic [DATA_W-1:0]  decImm;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == PH_W'(SLOT_LEN - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // instruction register: stage the upper byte, load the word with the lower
  always_ff @(posedge clk) begin
    if (rst) begin
      hiByte   <= '0;
      instrReg <= '0;
    end else if (phase == PH_W'(PH_FETCH_HI)) begin
      hiByte <= busByte;
    end else if (phase == PH_W'(PH_FETCH_LO)) begin
      instrReg <= {hiByte, busByte};
    end
  end

  // decoder: fields latched on the decode clock
  always_ff @(posedge clk) begin
    if (rst) begin
      decOp     <= OP_MOV;
      decUseImm <= 1'b0;
      decAddr   <= '0;
      decImm    <= '0;
    end else if (phase == PH_W'(PH_DECODE)) begin
      decOp     <= aluOp_e'(instrReg[15:13]);
      decUseImm <= instrReg[12] & instrReg[11];
      decAddr   <= instrReg[10:8];
      decImm    <= instrReg[7:0];
    end
  end

  always_comb begin
    strobe.aluEn   = (phase == PH_W'(PH_EXEC));
    strobe.wrEn    = (phase == PH_W'(PH_WB));
    strobe.op      = decOp;
    strobe.useImm  = decUseImm;
    strobe.regAddr = decAddr;
    strobe.imm     = decImm;
  end

  // R3: the word is taken only once both bytes are in
  a_r3_ir_load_window: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_W'(PH_FETCH_LO)) |=> $stable(instrReg));

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
(
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_MOV:  res = opA;
      OP_ADD:  res = opB + opA;
      OP_SUB:  res = opB - opA;
      OP_ABS:  res = opB[DATA_W-1] ? (~opB + 1'b1) : opB;
      OP_AND:  res = opB & opA;
      OP_OR:   res = opB | opA;
      OP_XOR:  res = opB ^ opA;
      OP_NOT:  res = ~opA;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
  import cpu8_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  ctrlStrobe_t                  strobe,
  output logic [DATA_W-1:0]            aluResult,
  output logic [NUM_REGS*DATA_W-1:0]   regContents
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [NUM_REGS-1:0]             wrSel;
  logic [DATA_W-1:0]               rdA;
  logic [DATA_W-1:0]               rdB;
  logic [DATA_W-1:0]               operandA;
  logic [DATA_W-1:0]               aluOut;

  // write-address decoder and flat view of the registers
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    assign wrSel[gi] = strobe.wrEn && (strobe.regAddr == RADDR_W'(gi));
    assign regContents[gi*DATA_W +: DATA_W] = regFile[gi];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regFile <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wrSel[i]) regFile[i] <= aluResult;
      end
    end
  end

  // two read multiplexers
  assign rdA = regFile[strobe.regAddr];
  assign rdB = regFile[strobe.regAddr];

  assign operandA = strobe.useImm ? strobe.imm : rdA;

  cpu8_alu u_alu (
    .op  (strobe.op),
    .opA (operandA),
    .opB (rdB),
    .res (aluOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      aluResult <= '0;
    end else if (strobe.aluEn) begin
      aluResult <= aluOut;
    end
  end

  // R3/R8: registers move only on a write strobe, result only on evaluate
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !strobe.wrEn |=> $stable(regFile));
  a_r3_result_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.aluEn |=> $stable(aluResult));
  // R6: absolute value is non-negative except for the most negative input
  a_r6_abs_nonneg: assert property (@(posedge clk) disable iff (rst)
    (strobe.aluEn && strobe.op == OP_ABS && rdB != 8'h80) |=> !aluResult[DATA_W-1]);

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int SLOT_LEN = 8,
  parameter int PROG_LEN = 4,
  parameter logic [PROG_LEN*INSTR_W-1:0] PROGRAM =
    {16'h6000, 16'h5840, 16'h3810, 16'h1820}
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [7:0]                  instrBus,
  output logic [7:0]                  aluResult,
  output logic [63:0]                 regContents
);

  localparam int PH_W = $clog2(SLOT_LEN);

  ctrlStrobe_t     strobe;
  logic [PH_W-1:0] fetchPhase;
  logic [PH_W-1:0] ctrlPhase;

  cpu8_fetch #(
    .SLOT_LEN (SLOT_LEN),
    .PROG_LEN (PROG_LEN),
    .PROGRAM  (PROGRAM)
  ) u_fetch (
    .clk     (clk),
    .rst     (rst),
    .busByte (instrBus),
    .phase   (fetchPhase)
  );

  cpu8_ctrl #(
    .SLOT_LEN (SLOT_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busByte (instrBus),
    .strobe  (strobe),
    .phase   (ctrlPhase)
  );

  cpu8_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .aluResult   (aluResult),
    .regContents (regContents)
  );

  // R3: the two slot counters never drift apart
  a_r3_phase_lockstep: assert property (@(posedge clk) disable iff (rst)
    fetchPhase == ctrlPhase);

endmodule

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;

  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 16;
  // word k sits at bits [16k+15:16k]
  localparam logic [PLEN*16-1:0] PROG = {
    16'hF95A, 16'hE500, 16'hDDFF, 16'hBDF0,
    16'h9D0F, 16'h1DC3, 16'h3355, 16'h5B01,
    16'h3B01, 16'h1B7F, 16'h6700, 16'h1F80,
    16'h68AB, 16'h5840, 16'h3810, 16'h1820
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  instrBus;
  logic [7:0]  aluResult;
  logic [63:0] regContents;

  cpu8_core #(.SLOT_LEN(8), .PROG_LEN(PLEN), .PROGRAM(PROG)) dut (
    .clk         (clk),
    .rst         (rst),
    .instrBus    (instrBus),
    .aluResult   (aluResult),
    .regContents (regContents)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         edgeNo;
    int         kind;   // 0 bus, 1 alu result, 2 register
    int         idx;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sbQ[$];
  int    edgeCount = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;

  always @(posedge clk) begin
    if (rst) edgeCount <= 0;
    else     edgeCount <= edgeCount + 1;
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // monitor: pop every item due at this edge count
  always @(negedge clk) begin
    if (!rst) begin
      while (sbQ.size() > 0 && sbQ[0].edgeNo == edgeCount) begin
        item_t it;
        it = sbQ.pop_front();
        case (it.kind)
          0: check(it.req, "bus", instrBus, it.exp);
          1: check(it.req, "alu result", aluResult, it.exp);
          default: check(it.req, $sformatf("R%0d content", it.idx),
                         regContents[it.idx*8 +: 8], it.exp);
        endcase
      end
    end
  end

  function automatic logic [7:0] refAlu(logic [15:0] w, logic [7:0] r);
    logic [7:0] a;
    a = (w[12] && w[11]) ? w[7:0] : r;
    case (w[15:13])
      3'b000:  return a;
      3'b001:  return r + a;
      3'b010:  return r - a;
      3'b011:  return r[7] ? (8'h00 - r) : r;
      3'b100:  return r & a;
      3'b101:  return r | a;
      3'b110:  return r ^ a;
      default: return ~a;
    endcase
  endfunction

  function automatic string opTag(logic [15:0] w);
    if (w[15:13] == 3'b011) return "R6";
    if (w[12] != w[11]) return "R4";
    if (w[15]) return "R7";
    return "R5";
  endfunction

  task automatic push(int e, int kind, int idx, logic [7:0] exp, string req);
    item_t it;
    it.edgeNo = e; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    sbQ.push_back(it);
  endtask

  // driver: run a reference model from reset and queue expected items
  task automatic planRun(int nInstr);
    logic [7:0] mr [8];
    logic [7:0] res;
    for (int i = 0; i < 8; i++) mr[i] = 8'h00;
    res = 8'h00;
    push(0, 1, 0, 8'h00, "R1");
    for (int i = 0; i < 8; i++) push(0, 2, i, 8'h00, "R1");
    for (int k = 0; k < nInstr; k++) begin
      int         b;
      int         rd;
      logic [15:0] w;
      logic [7:0]  nv;
      string       busTag;
      b  = 8 * k;
      w  = PROG[(k % PLEN)*16 +: 16];
      rd = int'(w[10:8]);
      busTag = (k == 0) ? "R1" : ((k >= PLEN) ? "R9" : "R2");
      push(b,     0, 0, w[15:8], busTag);
      push(b + 1, 0, 0, w[7:0],  "R2");
      push(b + 2, 0, 0, 8'h00,   "R2");
      push(b + 3, 1, 0, res,     "R3");
      nv = refAlu(w, mr[rd]);
      res = nv;
      push(b + 4, 1, 0, res, opTag(w));
      push(b + 4, 2, rd, mr[rd], "R3");
      mr[rd] = nv;
      for (int i = 0; i < 8; i++) begin
        if (i == rd) push(b + 5, 2, i, mr[i], (k == 3) ? "R10" : opTag(w));
        else         push(b + 5, 2, i, mr[i], "R8");
      end
    end
  endtask

  task automatic drainQueue();
    while (sbQ.size() > 0) @(negedge clk);
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    // run past the last word so the counter wraps (R9)
    planRun(PLEN + 2);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    drainQueue();
    // reset in the middle of a slot (R1)
    repeat (5) @(negedge clk);
    rst = 1'b1;
    planRun(4);
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    drainQueue();
    finished = 1'b1;
    finish();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

endmodule